// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the serial slave port of a converter controller. A host drives chip select, serial clock and serial data in. The block returns serial data out together with an output-enable flag. The serial pins are brought into the system clock domain and their edges are detected there. The port decodes each 8-bit command byte it receives. A register command moves a 32-bit word, MSB first, into or out of one of three control registers (offset, gain, configuration). A read command can also fetch the word on the converter's result input. Conversion and calibration commands leave the block as one-cycle strobes for the controller.

The host can recover from lost framing by sending a long run of ones followed by a zero. Fifteen or more 0xFF bytes followed by 0xFE is such a run. The run sends the port back to command mode from any phase and at any bit alignment. It leaves the register contents unchanged.

Top module: `cport_top`

## Requirements
- R1: After reset, offset reads 0x00000000, gain reads 0x01000000 and configuration reads 0x00000000. The port waits for a command byte.
- R2: Serial data in is sampled on rising serial-clock edges, MSB first. Serial-clock edges that arrive while chip select is high have no effect on framing or on any register.
- R3: Commands 0x01 (offset), 0x02 (gain) and 0x03 (configuration) take the next 32 bits as the new register value, MSB first. The register changes only after the 32nd bit. The port then returns to command mode.
- R4: Commands 0x09 (offset), 0x0A (gain), 0x0B (configuration) and 0x0C (result input, captured when the command completes) send 32 bits, bit 31 first. Each bit is presented after a falling serial-clock edge, so the host can sample it on the next rising edge. The port then returns to command mode.
- R5: Command 0x80 pulses `conv_single` for one system clock. Command 0xC0 pulses `conv_cont` for one system clock.
- R6: Command 0x85 pulses `cal_offset` for one system clock. Command 0x86 pulses `cal_gain` for one system clock. At most one strobe is high in any cycle.
- R7: In command mode, 0xFF is a no-op. Any other byte not listed in R3 to R6 (for example 0x04 or 0x10) is discarded. In both cases no strobe fires and the next byte is taken as a command.
- R8: A run of at least 127 consecutive one bits followed by a zero bit returns the port to command mode with byte alignment restored. This holds from any phase and any bit offset. Register contents are not disturbed.
- R9: `sdo_en` is low whenever `cs_n` is high, and high whenever `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Output drive enable; low means high impedance |
| conv_data | input | 32 | Conversion result offered to the read command 0x0C |
| offset_q | output | 32 | Offset register |
| gain_q | output | 32 | Gain register |
| cfg_q | output | 32 | Configuration register |
| conv_single | output | 1 | Single-conversion strobe |
| conv_cont | output | 1 | Continuous-conversion strobe |
| cal_offset | output | 1 | Offset-calibration strobe |
| cal_gain | output | 1 | Gain-calibration strobe |

## Verification
Each serial-clock edge is seen by the design three system clocks after it reaches the pin: two synchroniser stages, then the state register. Register updates and strobes therefore appear three clocks after the relevant rising edge, and a read bit appears three clocks after the falling edge. The bench holds each serial-clock level for six system clocks. It samples `sdo` at the end of the low half, registers six clocks after the final rising edge, and strobes on every falling system-clock edge. A scoreboard queue pairs each strobe with the command that should have caused it.

// File: rtl/cport_pkg.sv
package cport_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WR, OP_RD, OP_CONV1, OP_CONVC, OP_CALO, OP_CALG
  } op_e;

  localparam logic [2:0] SEL_OFF  = 3'd1;
  localparam logic [2:0] SEL_GAIN = 3'd2;
  localparam logic [2:0] SEL_CFG  = 3'd3;
  localparam logic [2:0] SEL_RES  = 3'd4;

  typedef struct packed {
    op_e        op;
    logic [2:0] sel;
  } cmd_t;

  // Command byte decode: register ops in upper nibble zero, bit 3 = read.
  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.op  = OP_NONE;
    c.sel = b[2:0];
    if (b[7:4] == 4'h0) begin
      if (b[2:0] inside {SEL_OFF, SEL_GAIN, SEL_CFG})
        c.op = b[3] ? OP_RD : OP_WR;
      else if (b[2:0] == SEL_RES && b[3])
        c.op = OP_RD;
    end else if (b[7] && b[5:0] == 6'd0) begin
      c.op = b[6] ? OP_CONVC : OP_CONV1;
    end else if (b == 8'h85) begin
      c.op = OP_CALO;
    end else if (b == 8'h86) begin
      c.op = OP_CALG;
    end
    return c;
  endfunction

endpackage

// File: rtl/cport_sync.sv
module cport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdi,
  input  logic cs_n,
  output logic rise,
  output logic fall,
  output logic sdi_s,
  output logic cs_act
);
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] sdi_p;
  logic [STAGES-1:0] cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sdi_p <= '0;
      cs_p  <= '1;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sclk};
      sdi_p <= {sdi_p[STAGES-2:0], sdi};
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
    end
  end

  assign rise   = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign fall   = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign sdi_s  = sdi_p[STAGES-1];
  assign cs_act = ~cs_p[STAGES-1];

  p_edges_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
endmodule

// File: rtl/cport_resync.sv
module cport_resync #(
  parameter int RUN = 127
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_ev,
  input  logic bit_val,
  output logic hit
);
  localparam int RW = $clog2(RUN + 1);
  logic [RW-1:0] run;

  assign hit = bit_ev && !bit_val && (run >= RW'(RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else if (bit_ev) begin
      if (!bit_val)
        run <= '0;
      else if (run != RW'(RUN))
        run <= run + 1'b1;
    end
  end

  p_run_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> run == '0);
endmodule

// File: rtl/cport_top.sv
module cport_top
  import cport_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          STAGES   = 2,
  parameter int          RUN      = 127,
  parameter logic [31:0] GAIN_RST = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_en,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] offset_q,
  output logic [DW-1:0] gain_q,
  output logic [DW-1:0] cfg_q,
  output logic          conv_single,
  output logic          conv_cont,
  output logic          cal_offset,
  output logic          cal_gain
);
  localparam int DCW = $clog2(DW);

  logic rise, fall, sdi_s, cs_act, bit_ev, fall_ev, resync_hit;
  phase_e          phase;
  logic [2:0]      bcnt;
  logic [DCW-1:0]  dcnt;
  logic [DW-1:0]   in_sr, out_sr, wr_word;
  logic [2:0]      sel;
  logic            sdo_q;
  logic [7:0]      cmd_byte;
  cmd_t            cmd;
  logic            cmd_ev, wr_ev, rd_last;

  cport_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .rise(rise), .fall(fall), .sdi_s(sdi_s), .cs_act(cs_act));

  assign bit_ev  = rise & cs_act;
  assign fall_ev = fall & cs_act;

  cport_resync #(.RUN(RUN)) u_resync (
    .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev), .bit_val(sdi_s), .hit(resync_hit));

  // Named internal events
  assign cmd_byte = {in_sr[6:0], sdi_s};
  assign cmd      = decode_cmd(cmd_byte);
  assign cmd_ev   = bit_ev && !resync_hit && phase == PH_CMD && bcnt == 3'd7;
  assign wr_word  = {in_sr[DW-2:0], sdi_s};
  assign wr_ev    = bit_ev && !resync_hit && phase == PH_WR && dcnt == DCW'(DW-1);
  assign rd_last  = bit_ev && !resync_hit && phase == PH_RD && dcnt == DCW'(DW-1);

  function automatic logic [DW-1:0] rd_mux(input logic [2:0] s);
    case (s)
      SEL_OFF:  return offset_q;
      SEL_GAIN: return gain_q;
      SEL_CFG:  return cfg_q;
      default:  return conv_data;
    endcase
  endfunction

  // Framing and shift paths
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      bcnt   <= '0;
      dcnt   <= '0;
      in_sr  <= '0;
      out_sr <= '0;
      sel    <= '0;
      sdo_q  <= 1'b0;
    end else if (resync_hit) begin
      phase <= PH_CMD;
      bcnt  <= '0;
      dcnt  <= '0;
      sdo_q <= 1'b0;
    end else if (bit_ev) begin
      in_sr <= wr_word;
      case (phase)
        PH_CMD: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            dcnt <= '0;
            sel  <= cmd.sel;
            if (cmd.op == OP_WR) phase <= PH_WR;
            if (cmd.op == OP_RD) begin
              phase  <= PH_RD;
              out_sr <= rd_mux(cmd.sel);
            end
          end
        end
        PH_WR: begin
          dcnt <= dcnt + 1'b1;
          if (wr_ev) phase <= PH_CMD;
        end
        default: begin
          dcnt <= dcnt + 1'b1;
          if (rd_last) begin
            phase <= PH_CMD;
            sdo_q <= 1'b0;
          end
        end
      endcase
    end else if (fall_ev && phase == PH_RD) begin
      sdo_q  <= out_sr[DW-1];
      out_sr <= {out_sr[DW-2:0], 1'b0};
    end
  end

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      gain_q   <= DW'(GAIN_RST);
      cfg_q    <= '0;
    end else if (wr_ev) begin
      case (sel)
        SEL_OFF:  offset_q <= wr_word;
        SEL_GAIN: gain_q   <= wr_word;
        default:  cfg_q    <= wr_word;
      endcase
    end
  end

  // Command strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_single <= 1'b0;
      conv_cont   <= 1'b0;
      cal_offset  <= 1'b0;
      cal_gain    <= 1'b0;
    end else begin
      conv_single <= cmd_ev && cmd.op == OP_CONV1;
      conv_cont   <= cmd_ev && cmd.op == OP_CONVC;
      cal_offset  <= cmd_ev && cmd.op == OP_CALO;
      cal_gain    <= cmd_ev && cmd.op == OP_CALG;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_en = ~cs_n;

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_single, conv_cont, cal_offset, cal_gain}));
  p_strobe_from_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_single || conv_cont || cal_offset || cal_gain) |-> $past(phase) == PH_CMD);
  p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable({offset_q, gain_q, cfg_q}));
  p_idle_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable({phase, bcnt, dcnt}));
  p_resync_to_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resync_hit |=> (phase == PH_CMD && bcnt == 3'd0));
  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD && !fall_ev && !bit_ev) |=> $stable(sdo_q));
endmodule

// File: tb/sim_cport_top.sv
module sim_cport_top;
  localparam int CLK_NS = 10;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [31:0] conv_data = 32'h0;
  logic [31:0] offset_q, gain_q, cfg_q;
  logic conv_single, conv_cont, cal_offset, cal_gain;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cport_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .conv_data(conv_data),
    .offset_q(offset_q), .gain_q(gain_q), .cfg_q(cfg_q),
    .conv_single(conv_single), .conv_cont(conv_cont),
    .cal_offset(cal_offset), .cal_gain(cal_gain));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    sdi = b; sclk = 1'b0; tick(HALF);
    seen = sdo; sclk = 1'b1; tick(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
  endtask

  task automatic put_word(input logic [31:0] w, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) put_bit(w[i], r[i]);
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [31:0] w);
    logic [31:0] r;
    put_byte(c); put_word(w, r);
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [31:0] r);
    put_byte(c); put_word(32'h0, r);
  endtask

  // Strobe monitor: pops expected strobe codes (1 single, 2 cont, 4 cal offset, 8 cal gain)
  always @(negedge clk) begin
    int code;
    code = {cal_gain, cal_offset, conv_cont, conv_single};
    if (rst_n && code != 0) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected strobe actual=%0d expected=none", code);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != code) begin
          errors++;
          $display("FAIL R5/R6 strobe actual=%0d expected=%0d", code, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(4); rst_n = 1'b1; tick(4);
    // R1 reset values, R9 high impedance while deselected
    chk("R1 offset", offset_q, 32'h0);
    chk("R1 gain", gain_q, 32'h0100_0000);
    chk("R1 cfg", cfg_q, 32'h0);
    chk("R9 deselected", {31'd0, sdo_en}, 32'd0);
    cs_n = 1'b0; tick(4);
    chk("R9 selected", {31'd0, sdo_en}, 32'd1);

    // R3 writes
    wr_reg(8'h01, 32'h1234_5678);
    chk("R3 offset write", offset_q, 32'h1234_5678);
    wr_reg(8'h02, 32'h8000_0001);
    chk("R3 gain write", gain_q, 32'h8000_0001);
    wr_reg(8'h03, 32'hA5A5_0F0F);
    chk("R3 cfg write", cfg_q, 32'hA5A5_0F0F);
    chk("R3 offset untouched", offset_q, 32'h1234_5678);

    // R4 reads
    rd_reg(8'h09, r); chk("R4 read offset", r, 32'h1234_5678);
    rd_reg(8'h0A, r); chk("R4 read gain", r, 32'h8000_0001);
    rd_reg(8'h0B, r); chk("R4 read cfg", r, 32'hA5A5_0F0F);
    conv_data = 32'hDEAD_BEEF;
    rd_reg(8'h0C, r); chk("R4 read result", r, 32'hDEAD_BEEF);

    // R5 / R6 strobes via scoreboard
    exp_q.push_back(1); put_byte(8'h80);
    exp_q.push_back(2); put_byte(8'hC0);
    exp_q.push_back(4); put_byte(8'h85);
    exp_q.push_back(8); put_byte(8'h86);
    tick(8);
    chk("R5/R6 all strobes seen", exp_q.size(), 0);

    // R2 edges while deselected ignored
    cs_n = 1'b1; tick(4);
    put_byte(8'h01); put_byte(8'h55);
    chk("R9 deselected during edges", {31'd0, sdo_en}, 32'd0);
    cs_n = 1'b0; tick(4);
    chk("R2 offset untouched", offset_q, 32'h1234_5678);
    rd_reg(8'h0A, r); chk("R2 framing kept", r, 32'h8000_0001);

    // R7 no-op and unknown bytes
    put_byte(8'hFF); put_byte(8'h04); put_byte(8'h10);
    chk("R7 cfg untouched", cfg_q, 32'hA5A5_0F0F);
    rd_reg(8'h0B, r); chk("R7 next command", r, 32'hA5A5_0F0F);

    // R8 resync from misaligned framing
    begin
      logic s;
      put_bit(1'b0, s); put_bit(1'b1, s); put_bit(1'b0, s);
    end
    for (int k = 0; k < 15; k++) put_byte(8'hFF);
    put_byte(8'hFE);
    chk("R8 offset kept", offset_q, 32'h1234_5678);
    chk("R8 gain kept", gain_q, 32'h8000_0001);
    rd_reg(8'h09, r); chk("R8 realigned read", r, 32'h1234_5678);
    exp_q.push_back(4); put_byte(8'h85);
    tick(8);
    chk("R8 strobe after resync", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule